// File: doc/BRIEF.md
# Sign-Magnitude Difference Unit

This block takes two non-negative operands in sign-magnitude form and returns their difference, also in sign-magnitude form. It never forms a two's-complement result. Instead, a magnitude comparator decides which operand is larger. Two banks of 2:1 selectors then route the larger magnitude to the minuend and the smaller one to the subtrahend. An unsigned subtractor produces the magnitude, and the comparison outcome becomes the sign.

The block is meant to feed a downstream stage that expects sign-magnitude values. A strobe travels alongside the operands, and the result appears in a register one clock after the strobe. Between strobes the result register keeps its last value. The magnitude width is a parameter, with a default of 3. An operand word is therefore one sign bit above the magnitude bits, 4 bits in the default build.

Top module: `smd_sub`

## Requirements
- R1: While reset is asserted (active low), `res_vld` is 0 and `res` is all zero.
- R2: `res_vld` equals the value `op_vld` had at the previous rising clock edge.
- R3: When `op_vld` is high and the magnitude of A is larger than that of B, `res` holds sign bit 0 (the top bit) and magnitude A−B (the lower MAG_W bits) after the next clock edge.
- R4: When `op_vld` is high and the magnitude of A is smaller than that of B, `res` holds sign bit 1 and magnitude B−A after the next clock edge.
- R5: When the magnitudes are equal, the result is +0 (all bits zero). A negative zero is never presented.
- R6: The top bit of each operand word is not used. Setting it to 1 gives the same result as setting it to 0.
- R7: While `op_vld` is low, `res` keeps the value it had, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_vld | input | 1 | Operands on `op_a`/`op_b` are to be taken this cycle |
| op_a | input | MAG_W+1 | Operand A: top bit sign (unused), lower bits magnitude |
| op_b | input | MAG_W+1 | Operand B: same layout as A |
| res_vld | output | 1 | Result register was loaded at the last edge |
| res | output | MAG_W+1 | A−B: top bit sign (1 = negative), lower bits magnitude |

## Verification
Two functions can meet in one cycle. While one result is on the output, the register can be taking in the next operand pair. A strobe can also drop at the same edge the last result lands, so the hold behaviour has to take over immediately. The bench provokes both cases by streaming all operand pairs back to back. It inserts idle cycles at regular intervals and drives unrelated operands during those idle cycles. A behavioural model predicts the strobe and the held or updated result, and the outputs are compared against it on every clock. The same sweep is then repeated with both operand sign bits forced high, and the outputs must come out identical.

// File: rtl/smd_pkg.sv
package smd_pkg;

    localparam int unsigned SMD_MAG_W_DEF = 3;

    // Sign encoding of the result word's top bit
    typedef enum logic {
        SGN_POS = 1'b0,
        SGN_NEG = 1'b1
    } smd_sgn_e;

endpackage

// File: rtl/smd_mag_cmp.sv
// Magnitude comparator: flags x < y with a LSB-to-MSB decision chain.
module smd_mag_cmp #(
    parameter int unsigned MAG_W = 3
) (
    input  logic [MAG_W-1:0] x_mag,
    input  logic [MAG_W-1:0] y_mag,
    output logic             x_lt_y
);

    logic [MAG_W:0] lt_chain;

    assign lt_chain[0] = 1'b0;

    for (genvar i = 0; i < MAG_W; i++) begin : g_bit
        // A higher bit that differs overrides everything decided below it
        assign lt_chain[i+1] = (~x_mag[i] & y_mag[i]) |
                               (~(x_mag[i] ^ y_mag[i]) & lt_chain[i]);
    end

    assign x_lt_y = lt_chain[MAG_W];

endmodule

// File: rtl/smd_swap.sv
// Pair of 2:1 selector banks: larger magnitude goes to big_mag.
module smd_swap #(
    parameter int unsigned MAG_W = 3
) (
    input  logic [MAG_W-1:0] a_mag,
    input  logic [MAG_W-1:0] b_mag,
    input  logic             swap,
    output logic [MAG_W-1:0] big_mag,
    output logic [MAG_W-1:0] small_mag
);

    for (genvar i = 0; i < MAG_W; i++) begin : g_mux
        assign big_mag[i]   = swap ? b_mag[i] : a_mag[i];
        assign small_mag[i] = swap ? a_mag[i] : b_mag[i];
    end

endmodule

// File: rtl/smd_usub.sv
// Unsigned ripple-borrow subtractor; caller guarantees min_mag >= sub_mag.
module smd_usub #(
    parameter int unsigned MAG_W = 3
) (
    input  logic [MAG_W-1:0] min_mag,
    input  logic [MAG_W-1:0] sub_mag,
    output logic [MAG_W-1:0] dif_mag
);

    logic [MAG_W-1:0] brw;

    assign brw[0] = 1'b0;

    for (genvar i = 0; i < MAG_W; i++) begin : g_stage
        assign dif_mag[i] = min_mag[i] ^ sub_mag[i] ^ brw[i];
        if (i < MAG_W - 1) begin : g_brw
            assign brw[i+1] = (~min_mag[i] & sub_mag[i]) |
                              (~(min_mag[i] ^ sub_mag[i]) & brw[i]);
        end
    end

endmodule

// File: rtl/smd_sub.sv
module smd_sub
    import smd_pkg::*;
#(
    parameter int unsigned MAG_W = SMD_MAG_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_vld,
    input  logic [MAG_W:0]   op_a,
    input  logic [MAG_W:0]   op_b,
    output logic             res_vld,
    output logic [MAG_W:0]   res
);

    localparam int unsigned WORD_W = MAG_W + 1;
    localparam int unsigned SGN_IX = WORD_W - 1;

    typedef struct packed {
        logic             vld;
        smd_sgn_e         sgn;
        logic [MAG_W-1:0] mag;
    } out_st_t;

    logic [MAG_W-1:0] a_mag;
    logic [MAG_W-1:0] b_mag;
    logic             a_lt_b;
    logic [MAG_W-1:0] big_mag;
    logic [MAG_W-1:0] small_mag;
    logic [MAG_W-1:0] dif_mag;
    logic             unused_sgn;

    out_st_t out_d;
    out_st_t out_q;

    assign a_mag      = op_a[MAG_W-1:0];
    assign b_mag      = op_b[MAG_W-1:0];
    assign unused_sgn = op_a[SGN_IX] | op_b[SGN_IX];

    smd_mag_cmp #(.MAG_W(MAG_W)) u_cmp (
        .x_mag  (a_mag),
        .y_mag  (b_mag),
        .x_lt_y (a_lt_b)
    );

    smd_swap #(.MAG_W(MAG_W)) u_swap (
        .a_mag     (a_mag),
        .b_mag     (b_mag),
        .swap      (a_lt_b),
        .big_mag   (big_mag),
        .small_mag (small_mag)
    );

    smd_usub #(.MAG_W(MAG_W)) u_usub (
        .min_mag (big_mag),
        .sub_mag (small_mag),
        .dif_mag (dif_mag)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = op_vld;
        if (op_vld) begin
            // equal magnitudes leave a_lt_b low, so zero is always positive
            out_d.sgn = a_lt_b ? SGN_NEG : SGN_POS;
            out_d.mag = dif_mag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '{vld: 1'b0, sgn: SGN_POS, mag: '0};
        end else begin
            out_q <= out_d;
        end
    end

    assign res_vld = out_q.vld;
    assign res     = {out_q.sgn == SGN_NEG, out_q.mag};

endmodule

// File: rtl/smd_sub_chk.sv
module smd_sub_chk #(
    parameter int unsigned MAG_W = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           op_vld,
    input logic [MAG_W:0] op_a,
    input logic [MAG_W:0] op_b,
    input logic           res_vld,
    input logic [MAG_W:0] res
);

    logic [MAG_W-1:0] am;
    logic [MAG_W-1:0] bm;
    assign am = op_a[MAG_W-1:0];
    assign bm = op_b[MAG_W-1:0];

    assert_vld_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld |=> res_vld);

    assert_vld_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_vld |=> !res_vld);

    assert_pos_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && am > bm) |=> (res[MAG_W] == 1'b0 &&
            res[MAG_W-1:0] == $past(am) - $past(bm)));

    assert_neg_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && am < bm) |=> (res[MAG_W] == 1'b1 &&
            res[MAG_W-1:0] == $past(bm) - $past(am)));

    assert_pos_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && am == bm) |=> (res == '0));

    assert_no_neg_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> !(res[MAG_W] && res[MAG_W-1:0] == '0));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !op_vld |=> $stable(res));

endmodule

bind smd_sub smd_sub_chk #(.MAG_W(MAG_W)) u_smd_sub_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_vld  (op_vld),
    .op_a    (op_a),
    .op_b    (op_b),
    .res_vld (res_vld),
    .res     (res)
);

// File: tb/test_smd_sub.sv
`timescale 1ns/1ps
module test_smd_sub;

    localparam int M   = 3;
    localparam int TOP = 1 << M;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_vld = 1'b0;
    logic [M:0]   op_a = '0;
    logic [M:0]   op_b = '0;
    logic         res_vld;
    logic [M:0]   res;

    int total = 0;
    int bad   = 0;

    // behavioural model state
    int exp_vld = 0;
    int exp_res = 0;
    int last_sgn_clear [TOP*TOP];

    always #2.5 clk = ~clk;

    smd_sub #(.MAG_W(M)) i_smd_sub (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_vld  (op_vld),
        .op_a    (op_a),
        .op_b    (op_b),
        .res_vld (res_vld),
        .res     (res)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model(input int a, input int b);
        int d;
        d = (a % TOP) - (b % TOP);
        if (d < 0) return TOP + (-d);   // sign bit set, magnitude b-a
        return d;                       // includes +0 for equal magnitudes
    endfunction

    function automatic string tag_for(input int e);
        if (e == 0)   return "R5";
        if (e >= TOP) return "R4";
        return "R3";
    endfunction

    // compare outputs with the model, then present new inputs
    task automatic step(input bit v, input int a, input int b);
        @(negedge clk);
        check(int'(res_vld) == exp_vld, "R2", int'(res_vld), exp_vld);
        if (exp_vld != 0)
            check(int'(res) == exp_res, tag_for(exp_res), int'(res), exp_res);
        else
            check(int'(res) == exp_res, "R7", int'(res), exp_res);
        op_vld = v;
        op_a   = M'(a) + (M+1)'(a & TOP);
        op_b   = M'(b) + (M+1)'(b & TOP);
        exp_vld = v ? 1 : 0;
        if (v) exp_res = model(a, b);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(res_vld == 1'b0, "R1", int'(res_vld), 0);
        check(res == '0, "R1", int'(res), 0);
        rst_n = 1'b1;

        // sweep all pairs, idle cycles with junk operands every fifth pair
        for (int i = 0; i < TOP*TOP; i++) begin
            step(1'b1, i / TOP, i % TOP);
            last_sgn_clear[i] = exp_res;
            if (i % 5 == 4) step(1'b0, (i * 3) % TOP, (i * 5 + 1) % TOP);
        end
        step(1'b0, 0, 0);

        // sign bits forced high must give the same results (R6)
        for (int i = 0; i < TOP*TOP; i++) begin
            step(1'b1, TOP + i / TOP, TOP + i % TOP);
            @(negedge clk);
            check(int'(res) == last_sgn_clear[i], "R6", int'(res), last_sgn_clear[i]);
            op_vld  = 1'b0;
            op_a    = '1;
            op_b    = '0;
            exp_vld = 0;
            step(1'b0, 0, 0);
        end
        step(1'b0, 0, 0);
        step(1'b0, 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule